// File: doc/BRIEF.md
# Register-Programmed Clock Divider

This block divides its input clock by a ratio held in a bit field of a 32-bit control word. The field's position and width are parameters. One of four decodings is chosen at build time:
- the code plus one;
- the code itself;
- two raised to the code;
- a lookup into a parameter table in which a zero entry marks an illegal code.

Software writes the whole word through a simple write port and reads it back combinationally.

Two outputs are produced: a one-cycle `tick_o` at the start of every output period, and a divided clock `clk_o`. A written ratio goes through two stages:
- It becomes pending either at once, or, when a latch bit position is configured, only on a write that clears a latch bit that was stored as one.
- The pending ratio then enters the counter only when the current output period ends, so no runt pulse appears.

An autoidle enable bit, optionally inverted, lets an idle request stop the output at the end of its current period.

Top module: `regclk_div`

## Requirements
- R1: After reset the read data and `err_o` are zero and the block divides by 1, so `tick_o` is high in every cycle.
- R2: In minus-one mode a field code c divides by c+1; with the bench setting the field occupies bits 8:4.
- R3: In one-based mode the divisor equals the code; code 0 is a zero divisor and the output runs at the input rate (tick every cycle).
- R4: In power-of-two mode code c divides by 2^c; with the bench setting the field starts at bit 2.
- R5: In table mode code i selects table entry i; the default entries for codes 0, 1, 2, 3 are 4, 8, 0, 16, and the field starts at bit 8.
- R6: A code whose table entry is zero, or that lies beyond the table, leaves the ratio unchanged and sets `err_o`, which stays high until reset.
- R7: With a latch bit configured (bit 12 in the bench), a new code is committed only by a write that carries the latch bit as 0 while the stored bit is 1; any other write leaves the ratio unchanged.
- R8: A committed ratio is applied only when the current output period ends; the period running at commit time keeps its old length.
- R9: For a divisor N of 2 or more, `clk_o` is high during the first floor(N/2) cycles of each period, starting with the cycle in which `tick_o` is high. For N of 1 or less, `clk_o` follows the input clock.
- R10: Autoidle is enabled when the autoidle bit XOR the invert option is 1 (bench: bit 13, inverted). While it is enabled and `idle_req_i` is high, the output stops at the end of the current period, with `tick_o` low and `clk_o` low. It resumes when either condition clears.
- R11: `rd_data_o` returns the last word written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Control word to write |
| rd_data_o | output | 32 | Stored control word |
| idle_req_i | input | 1 | Idle request, honoured when autoidle is enabled |
| tick_o | output | 1 | One-cycle pulse at the start of each output period |
| clk_o | output | 1 | Divided clock |
| err_o | output | 1 | Sticky flag for an illegal code commit |

## Verification
The pending divisor, the active divisor and the phase counter can each hold a wrong value. Any of these faults shows up at the ports within one or two output periods: the spacing between `tick_o` pulses changes, or the high time of `clk_o` changes. A commit applied too early shortens the period in which the write lands, and the boundary test measures exactly that period. A failure of the error path shows at once on `err_o`, and on the following period as a changed spacing.

// File: rtl/regclk_div_pkg.sv
`timescale 1ns/1ps
package regclk_div_pkg;
    typedef enum logic [1:0] {
        ENC_MINUS1  = 2'd0,
        ENC_ONEBASE = 2'd1,
        ENC_POW2    = 2'd2,
        ENC_TABLE   = 2'd3
    } enc_e;
endpackage

// File: rtl/regclk_div_decode.sv
`timescale 1ns/1ps
module regclk_div_decode #(
    parameter regclk_div_pkg::enc_e MODE = regclk_div_pkg::ENC_MINUS1,
    parameter int FW    = 5,
    parameter int DIV_W = 16,
    parameter int NT    = 4,
    parameter logic [NT*DIV_W-1:0] TBL = '0
) (
    input  logic [FW-1:0]    code_i,
    output logic [DIV_W-1:0] div_o,
    output logic             legal_o
);
    generate
        if (MODE == regclk_div_pkg::ENC_MINUS1) begin : g_minus1
            assign div_o   = DIV_W'(code_i) + DIV_W'(1);
            assign legal_o = 1'b1;
        end else if (MODE == regclk_div_pkg::ENC_ONEBASE) begin : g_onebase
            assign div_o   = DIV_W'(code_i);
            assign legal_o = 1'b1;
        end else if (MODE == regclk_div_pkg::ENC_POW2) begin : g_pow2
            assign div_o   = DIV_W'(1) << code_i;
            assign legal_o = 1'b1;
        end else begin : g_table
            always_comb begin
                div_o   = '0;
                legal_o = 1'b0;
                if (int'(code_i) < NT) begin
                    div_o   = TBL[int'(code_i)*DIV_W +: DIV_W];
                    legal_o = (div_o != '0);
                end
            end
        end
    endgenerate
endmodule

// File: rtl/regclk_div_gen.sv
`timescale 1ns/1ps
module regclk_div_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DIV_W-1:0] pend_i,
    input  logic             stop_req_i,
    output logic [DIV_W-1:0] act_o,
    output logic [DIV_W-1:0] cnt_o,
    output logic             run_o,
    output logic             tick_o,
    output logic             clk_o
);
    typedef struct packed {
        logic [DIV_W-1:0] act;
        logic [DIV_W-1:0] cnt;
        logic             run;
        logic             phase;
    } gen_t;

    gen_t q, d;
    logic bypass_q;
    logic wrap;

    assign bypass_q = (q.act <= DIV_W'(1));

    always_comb begin
        d    = q;
        wrap = !q.run || bypass_q || (q.cnt == q.act - DIV_W'(1));
        if (wrap) begin
            d.act = pend_i;
            d.cnt = '0;
            d.run = !stop_req_i;
        end else begin
            d.cnt = q.cnt + DIV_W'(1);
        end
        d.phase = d.run && (d.act > DIV_W'(1)) && (d.cnt < (d.act >> 1));
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q.act   <= DIV_W'(1);
            q.cnt   <= '0;
            q.run   <= 1'b1;
            q.phase <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign act_o  = q.act;
    assign cnt_o  = q.cnt;
    assign run_o  = q.run;
    assign tick_o = q.run && (q.cnt == '0);
    assign clk_o  = bypass_q ? (clk_i & q.run) : q.phase;
endmodule

// File: rtl/regclk_div.sv
`timescale 1ns/1ps
module regclk_div #(
    parameter regclk_div_pkg::enc_e MODE = regclk_div_pkg::ENC_MINUS1,
    parameter int SHIFT     = 0,
    parameter int MAX_CODE  = 31,
    parameter int DIV_W     = 16,
    parameter int NT        = 4,
    parameter logic [NT*DIV_W-1:0] TBL = {16'd16, 16'd0, 16'd8, 16'd4},
    parameter int LATCH_BIT = -1,
    parameter int AI_BIT    = 31,
    parameter bit AI_INV    = 1'b0
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        wr_en_i,
    input  logic [31:0] wr_data_i,
    output logic [31:0] rd_data_o,
    input  logic        idle_req_i,
    output logic        tick_o,
    output logic        clk_o,
    output logic        err_o
);
    localparam int FW       = (MAX_CODE < 1) ? 1 : $clog2(MAX_CODE + 1);
    localparam bit LATCH_ON = (LATCH_BIT >= 0);
    localparam int LB       = LATCH_ON ? LATCH_BIT : 0;

    typedef struct packed {
        logic [31:0]      ctrl;
        logic [DIV_W-1:0] pend;
        logic             err;
    } reg_t;

    reg_t q, d;
    logic [DIV_W-1:0] dec_div;
    logic             dec_legal;
    logic             commit;
    logic [DIV_W-1:0] act_w, cnt_w;
    logic             run_w;
    logic             stop_req;

    regclk_div_decode #(
        .MODE(MODE), .FW(FW), .DIV_W(DIV_W), .NT(NT), .TBL(TBL)
    ) u_dec (
        .code_i (wr_data_i[SHIFT +: FW]),
        .div_o  (dec_div),
        .legal_o(dec_legal)
    );

    always_comb begin
        d      = q;
        commit = wr_en_i;
        if (LATCH_ON) begin
            commit = wr_en_i && q.ctrl[LB] && !wr_data_i[LB];
        end
        if (wr_en_i) begin
            d.ctrl = wr_data_i;
        end
        if (commit) begin
            if (dec_legal) begin
                d.pend = dec_div;
            end else begin
                d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q.ctrl <= '0;
            q.pend <= DIV_W'(1);
            q.err  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign stop_req = (q.ctrl[AI_BIT] ^ AI_INV) && idle_req_i;

    regclk_div_gen #(.DIV_W(DIV_W)) u_gen (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .pend_i    (q.pend),
        .stop_req_i(stop_req),
        .act_o     (act_w),
        .cnt_o     (cnt_w),
        .run_o     (run_w),
        .tick_o    (tick_o),
        .clk_o     (clk_o)
    );

    assign rd_data_o = q.ctrl;
    assign err_o     = q.err;
endmodule

// File: rtl/regclk_div_chk.sv
`timescale 1ns/1ps
module regclk_div_chk #(
    parameter int DIV_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [DIV_W-1:0] act_w,
    input logic [DIV_W-1:0] cnt_w,
    input logic             run_w,
    input logic             tick_o,
    input logic             err_o,
    input logic [DIV_W-1:0] pend
);
    AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (act_w > DIV_W'(1)) |-> (cnt_w < act_w)); // R8

    AST_RATIO_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(act_w) |-> $past(!run_w || act_w <= DIV_W'(1) || cnt_w == act_w - DIV_W'(1))); // R8

    AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(err_o) |-> err_o); // R6

    AST_ILLEGAL_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(err_o) |-> $stable(pend)); // R6

    AST_STOPPED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_w |-> !tick_o); // R10
endmodule

bind regclk_div regclk_div_chk #(.DIV_W(DIV_W)) chk_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .act_w (act_w),
    .cnt_w (cnt_w),
    .run_w (run_w),
    .tick_o(tick_o),
    .err_o (err_o),
    .pend  (q.pend)
);

// File: tb/regclk_div_tb_top.sv
`timescale 1ns/1ps
module regclk_div_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        idle_req = 1'b0;
    logic        wen [4];
    logic [31:0] wd  [4];
    logic [31:0] rd  [4];
    logic        tick[4];
    logic        dclk[4];
    logic        err [4];

    int checks = 0;
    int errors = 0;

    typedef struct {
        int    idx;
        int    exp;
        string tag;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    regclk_div #(.MODE(regclk_div_pkg::ENC_MINUS1), .SHIFT(4), .MAX_CODE(31),
                 .LATCH_BIT(12), .AI_BIT(13), .AI_INV(1'b1)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wen[0]), .wr_data_i(wd[0]),
        .rd_data_o(rd[0]), .idle_req_i(idle_req), .tick_o(tick[0]),
        .clk_o(dclk[0]), .err_o(err[0]));

    regclk_div #(.MODE(regclk_div_pkg::ENC_ONEBASE), .SHIFT(0), .MAX_CODE(15),
                 .AI_BIT(8), .AI_INV(1'b0)) u1 (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wen[1]), .wr_data_i(wd[1]),
        .rd_data_o(rd[1]), .idle_req_i(idle_req), .tick_o(tick[1]),
        .clk_o(dclk[1]), .err_o(err[1]));

    regclk_div #(.MODE(regclk_div_pkg::ENC_POW2), .SHIFT(2), .MAX_CODE(4)) u2 (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wen[2]), .wr_data_i(wd[2]),
        .rd_data_o(rd[2]), .idle_req_i(idle_req), .tick_o(tick[2]),
        .clk_o(dclk[2]), .err_o(err[2]));

    regclk_div #(.MODE(regclk_div_pkg::ENC_TABLE), .SHIFT(8), .MAX_CODE(3)) u3 (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wen[3]), .wr_data_i(wd[3]),
        .rd_data_o(rd[3]), .idle_req_i(idle_req), .tick_o(tick[3]),
        .clk_o(dclk[3]), .err_o(err[3]));

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(int idx, logic [31:0] data);
        @(negedge clk);
        wen[idx] = 1'b1;
        wd[idx]  = data;
        @(negedge clk);
        wen[idx] = 1'b0;
    endtask

    task automatic wait_tick(int idx, output int n);
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (tick[idx] || n >= 500) break;
        end
    endtask

    // driver side: push an expected period
    task automatic expect_period(int idx, int exp, string tag);
        item_t it;
        it.idx = idx;
        it.exp = exp;
        it.tag = tag;
        sb.push_back(it);
        monitor_pop();
    endtask

    // monitor side: pop, settle past the pending wrap, measure, compare
    task automatic monitor_pop();
        item_t it;
        int n;
        while (sb.size() > 0) begin
            it = sb.pop_front();
            wait_tick(it.idx, n);
            wait_tick(it.idx, n);
            wait_tick(it.idx, n);
            chk(it.tag, n, it.exp);
        end
    endtask

    function automatic logic [31:0] w0(int code, bit latch, bit ai);
        return (32'(code) << 4) | (32'(latch) << 12) | (32'(ai) << 13);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        int h;
        int t;
        for (int i = 0; i < 4; i++) begin
            wen[i] = 1'b0;
            wd[i]  = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 rd_data", int'(rd[0]), 0);
        chk("R1 err", int'(err[3]), 0);
        expect_period(0, 1, "R1 reset period");

        // R7 write without latch clear does not commit
        wr(0, w0(2, 1'b0, 1'b0));
        expect_period(0, 1, "R7 no commit");
        chk("R11 readback", int'(rd[0]), int'(w0(2, 1'b0, 1'b0)));
        wr(0, w0(2, 1'b1, 1'b0));
        expect_period(0, 1, "R7 latch set only");
        wr(0, w0(2, 1'b0, 1'b0));
        expect_period(0, 3, "R2 R7 code 2 divides by 3");

        // R2 / R9 code 5 -> 6, duty 3
        wr(0, w0(5, 1'b1, 1'b0));
        wr(0, w0(5, 1'b0, 1'b0));
        expect_period(0, 6, "R2 code 5");
        wait_tick(0, n);
        h = 0;
        for (int i = 0; i < 6; i++) begin
            if (dclk[0]) h++;
            @(negedge clk);
        end
        chk("R9 duty div6", h, 3);
        wr(0, w0(4, 1'b1, 1'b0));
        wr(0, w0(4, 1'b0, 1'b0));
        expect_period(0, 5, "R2 code 4");
        wait_tick(0, n);
        h = 0;
        for (int i = 0; i < 5; i++) begin
            if (dclk[0]) h++;
            @(negedge clk);
        end
        chk("R9 duty div5", h, 2);

        // R10 autoidle (inverted bit 13 = 0 means enabled)
        wr(0, w0(5, 1'b1, 1'b0));
        wr(0, w0(5, 1'b0, 1'b0));
        expect_period(0, 6, "R10 pre idle");
        idle_req = 1'b1;
        repeat (12) @(negedge clk);
        t = 0;
        h = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (tick[0]) t++;
            if (dclk[0]) h++;
        end
        chk("R10 ticks while idle", t, 0);
        chk("R10 clk low while idle", h, 0);
        wr(0, w0(5, 1'b0, 1'b1));
        expect_period(0, 6, "R10 resume when disabled");
        idle_req = 1'b0;

        // R3 one-based
        wr(1, 32'd3);
        expect_period(1, 3, "R3 code 3");
        wr(1, 32'd0);
        expect_period(1, 1, "R3 zero divisor");
        wr(1, 32'd1);
        expect_period(1, 1, "R3 code 1");

        // R8 change lands mid-period
        wr(1, 32'd8);
        expect_period(1, 8, "R3 code 8");
        wait_tick(1, n);
        wr(1, 32'd2);
        wait_tick(1, n);
        chk("R8 old period kept", n + 2, 8);
        expect_period(1, 2, "R8 new period");

        // R4 power of two, field at bit 2
        wr(2, 32'd2 << 2);
        expect_period(2, 4, "R4 code 2");
        wr(2, 32'd3 << 2);
        expect_period(2, 8, "R4 code 3");

        // R5 / R6 table
        wr(3, 32'd0 << 8);
        expect_period(3, 4, "R5 code 0");
        wr(3, 32'd3 << 8);
        expect_period(3, 16, "R5 code 3");
        wr(3, 32'd2 << 8);
        chk("R6 err set", int'(err[3]), 1);
        expect_period(3, 16, "R6 ratio kept");
        wr(3, 32'd1 << 8);
        chk("R6 err sticky", int'(err[3]), 1);
        expect_period(3, 8, "R5 code 1");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule